// File: doc/BRIEF.md
# Alarm Disarm Challenge Sequencer

This block decides when a digital alarm clock may fall silent. When the alarm fires, the buzzer turns on. The first button press only buys a short quiet period. To disarm the alarm, the user must then press a run of pseudo-randomly chosen buttons. The clock has six buttons. Each one sits under one of six indicators: the four seven-segment digits, the seconds colon and the AM/PM lamp. The block prompts the user for each button by blinking only the indicator that sits above it.

The same challenge cancels an armed alarm ahead of its scheduled time, and in that case the buzzer stays silent. A wrong press starts the run again from zero. If the quiet period ends before the run is complete, the buzzer sounds again and the run keeps its progress.

The surrounding clock supplies the one-hertz tick, a fast blink enable, debounced buttons, an alarm-fire pulse and a cancel request. Timekeeping, alarm storage, display drive and debouncing are not part of this block.

Top module: `alarm_disarm_seq`

## Requirements
- R1: After `rst_n` is held low at a clock edge, the block is idle. In this state `buzzer` is 0, `blink` is all zero and `disarmed` is 0. Button presses in idle have no effect: `buzzer` and `blink` stay 0.
- R2: An `alarm_fire` pulse in idle turns `buzzer` on in the next cycle. While the alarm rings, `blink` stays all zero.
- R3: While ringing, the first rising edge on any button turns `buzzer` off in the next cycle and starts the challenge. From then on, `blink` has at most one bit set. Bit i set means "press button i". The bits show only while an internal blink phase is high. That phase is low after reset and toggles on every `blink_tick` cycle.
- R4: A correct press is a cycle in which the only rising button edge is on the prompted button. It advances the press count, and a new prompt shows in the next cycle. Targets are drawn from a 16-bit maximal-length LFSR that never holds zero, reduced modulo 6.
- R5: The tenth correct press in a run makes `disarmed` high for exactly one cycle. In that cycle `buzzer` is 0 and `blink` is all zero, and the block is back in idle.
- R6: Any other rising edge during the challenge resets the press count to zero and draws a new target. This covers a wrong button and several buttons at once.
- R7: A button held high counts as one press, however many cycles it is held.
- R8: The quiet period lasts 60 `tick_1hz` pulses. After the 60th pulse, `buzzer` turns back on while the challenge continues. Presses still count, and the press count is kept.
- R9: A `cancel_req` pulse in idle starts the challenge with `buzzer` off. Completing it gives the R5 pulse, and `buzzer` never turns on.
- R10: An `alarm_fire` pulse during a cancel challenge turns `buzzer` on in the next cycle, with no quiet period. The challenge and its count carry on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_fire | input | 1 | One-cycle pulse when the alarm time is reached |
| cancel_req | input | 1 | One-cycle pulse requesting early cancellation |
| tick_1hz | input | 1 | One-cycle pulse each second |
| blink_tick | input | 1 | Enable that toggles the blink phase |
| btn | input | 6 | Debounced buttons, bit i under indicator i |
| buzzer | output | 1 | Buzzer enable |
| blink | output | 6 | Per-indicator blink enables |
| disarmed | output | 1 | One-cycle pulse when the alarm is disarmed |

## Verification
The assertions assume three things about the inputs. The buttons are already debounced and synchronous to `clk`. `alarm_fire`, `cancel_req` and `tick_1hz` are single-cycle pulses. A rising edge is only seen if the button was low in an earlier cycle.

The stimulus follows these assumptions. Every press is one cycle high followed by at least one cycle low, except in the hold scenario. Every pulse input is raised for exactly one cycle, on a falling clock edge. The bench learns each target only through the `blink` port, after setting the blink phase high.

// File: rtl/alarm_chal_pkg.sv
// Shared types for the alarm disarm challenge sequencer.
// Assumes nothing beyond a single clock domain.
package alarm_chal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RING = 2'd1,
        ST_CHAL = 2'd2
    } chal_state_e;
endpackage

// File: rtl/chal_lfsr.sv
// Free-running Galois LFSR used as the target source.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero,
// so the register never reaches the all-zero lock-up state.
module chal_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] lfsr_q;

    // Advance one step on every clock; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else if (lfsr_q[0])
            lfsr_q <= (lfsr_q >> 1) ^ TAPS;
        else
            lfsr_q <= lfsr_q >> 1;
    end

    assign value = lfsr_q;

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/btn_edge.sv
// Rising-edge detector for a vector of debounced buttons.
// Assumes the inputs are already synchronous to clk; a held level
// yields a single one-cycle pulse.
module btn_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // Remember last cycle's button levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= level;
    end

    assign rise = level & ~prev_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7
        rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/snooze_timer.sv
// Counts down the quiet period in one-hertz ticks.
// Assumes tick is a one-cycle pulse; load wins over clear and tick.
module snooze_timer #(
    parameter int TICKS = 60,
    localparam int CW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    input  logic tick,
    output logic running
);
    logic [CW-1:0] cnt_q;

    // Load, clear or count down the remaining quiet ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(TICKS);
        else if (clear)
            cnt_q <= '0;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign running = (cnt_q != '0);

    // R8
    snooze_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TICKS));
    // R8
    snooze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/alarm_disarm_seq.sv
// Alarm silencing controller: rings on alarm_fire, quiets on the first
// press, then demands STEPS correct prompted presses to disarm. A cancel
// request runs the same challenge silently. Assumes debounced, synchronous
// buttons and single-cycle pulse inputs.
module alarm_disarm_seq #(
    parameter int NUM_BTN      = 6,
    parameter int STEPS        = 10,
    parameter int SNOOZE_TICKS = 60,
    parameter int LFSR_W       = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alarm_fire,
    input  logic               cancel_req,
    input  logic               tick_1hz,
    input  logic               blink_tick,
    input  logic [NUM_BTN-1:0] btn,
    output logic               buzzer,
    output logic [NUM_BTN-1:0] blink,
    output logic               disarmed
);
    import alarm_chal_pkg::*;

    localparam int TW = $clog2(NUM_BTN);
    localparam int SW = $clog2(STEPS);

    chal_state_e        state_q;
    logic               sounding_q;
    logic [SW-1:0]      step_q;
    logic [TW-1:0]      target_q;
    logic               phase_q;
    logic               disarmed_q;
    logic [LFSR_W-1:0]  lfsr_val;
    logic [NUM_BTN-1:0] rise;
    logic [NUM_BTN-1:0] target_oh;
    logic [TW-1:0]      pick;
    logic               any_rise, hit, last_step;
    logic               snz_load, snz_clear, snz_running;

    chal_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .value(lfsr_val));

    btn_edge #(.N(NUM_BTN)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(btn), .rise(rise));

    snooze_timer #(.TICKS(SNOOZE_TICKS)) u_snooze (
        .clk(clk), .rst_n(rst_n), .load(snz_load), .clear(snz_clear),
        .tick(tick_1hz), .running(snz_running));

    // Decode press classification and next target.
    always_comb begin
        pick      = TW'(lfsr_val % LFSR_W'(NUM_BTN));
        target_oh = NUM_BTN'(1) << target_q;
        any_rise  = |rise;
        hit       = (state_q == ST_CHAL) && (rise == target_oh);
        last_step = (step_q == SW'(STEPS - 1));
        snz_load  = (state_q == ST_RING) && any_rise;
        snz_clear = (state_q == ST_CHAL) && (alarm_fire || (hit && last_step));
    end

    // Main sequencing: idle, ringing, challenge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sounding_q <= 1'b0;
            step_q     <= '0;
            target_q   <= '0;
            disarmed_q <= 1'b0;
        end else begin
            disarmed_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (alarm_fire) begin
                        state_q    <= ST_RING;
                        sounding_q <= 1'b1;
                    end else if (cancel_req) begin
                        state_q    <= ST_CHAL;
                        sounding_q <= 1'b0;
                        step_q     <= '0;
                        target_q   <= pick;
                    end
                end
                ST_RING: begin
                    if (any_rise) begin
                        state_q  <= ST_CHAL;
                        step_q   <= '0;
                        target_q <= pick;
                    end
                end
                ST_CHAL: begin
                    if (alarm_fire)
                        sounding_q <= 1'b1;
                    if (hit) begin
                        if (last_step) begin
                            state_q    <= ST_IDLE;
                            sounding_q <= 1'b0;
                            step_q     <= '0;
                            disarmed_q <= 1'b1;
                        end else begin
                            step_q   <= step_q + 1'b1;
                            target_q <= pick;
                        end
                    end else if (any_rise) begin
                        step_q   <= '0;
                        target_q <= pick;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Blink phase toggles on each blink enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (blink_tick)
            phase_q <= ~phase_q;
    end

    // Drive the outputs from state.
    always_comb begin
        buzzer   = (state_q == ST_RING) ||
                   ((state_q == ST_CHAL) && sounding_q && !snz_running);
        blink    = ((state_q == ST_CHAL) && phase_q) ? target_oh : '0;
        disarmed = disarmed_q;
    end

    // R3
    blink_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blink));
    // R3
    target_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        target_q < TW'(NUM_BTN));
    // R5
    disarm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarmed |=> !disarmed);
    // R5
    disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarmed |-> (!buzzer && blink == '0));
    // R5
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_q < SW'(STEPS));
    // R6
    wrong_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHAL && any_rise && !hit) |=> step_q == '0);
    // R9
    silent_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHAL && !sounding_q && !alarm_fire) |=> !buzzer);
endmodule

// File: tb/tb_alarm_disarm_seq.sv
module tb_alarm_disarm_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_fire = 1'b0, cancel_req = 1'b0;
    logic       tick_1hz = 1'b0, blink_tick = 1'b0;
    logic [5:0] btn = '0;
    logic       buzzer, disarmed;
    logic [5:0] blink;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_disarm_seq dut (
        .clk(clk), .rst_n(rst_n), .alarm_fire(alarm_fire),
        .cancel_req(cancel_req), .tick_1hz(tick_1hz),
        .blink_tick(blink_tick), .btn(btn), .buzzer(buzzer),
        .blink(blink), .disarmed(disarmed));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic press(input int i);
        @(negedge clk); btn = 6'(1) << i;
        @(negedge clk); btn = '0;
    endtask

    task automatic get_target(output int t, input string req);
        t = 0;
        for (int i = 0; i < 6; i++) if (blink[i]) t = i;
        chk($countones(blink) == 1, req, int'(blink), 1 << t);
    endtask

    // Press n prompted buttons; disarmed expected only after the last when exp_done.
    task automatic do_steps(input int n, input bit exp_done, input string req);
        for (int k = 0; k < n; k++) begin
            int t;
            get_target(t, "R4");
            press(t);
            if (k < n - 1) chk(disarmed == 1'b0, req, disarmed, 0);
            else           chk(disarmed == exp_done, req, disarmed, exp_done);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset
        chk(buzzer == 0 && blink == 0 && disarmed == 0, "R1", {buzzer, disarmed}, 0);
        press(2);
        // R1: presses in idle ignored
        chk(buzzer == 0 && blink == 0, "R1", int'(blink), 0);
        pulse(blink_tick);  // phase high from now on
    endtask

    task automatic t_snooze;
        int t;
        pulse(alarm_fire);
        chk(buzzer == 1, "R2", buzzer, 1);
        chk(blink == 0, "R2", int'(blink), 0);
        press(0);
        chk(buzzer == 0, "R3", buzzer, 0);
        get_target(t, "R3");
        pulse(blink_tick);
        chk(blink == 0, "R3 phase low", int'(blink), 0);
        pulse(blink_tick);
        chk($countones(blink) == 1, "R3 phase high", int'(blink), 1);
        do_steps(3, 1'b0, "R4");
        for (int k = 0; k < 59; k++) pulse(tick_1hz);
        chk(buzzer == 0, "R8 before expiry", buzzer, 0);
        pulse(tick_1hz);
        chk(buzzer == 1, "R8 after expiry", buzzer, 1);
        do_steps(6, 1'b0, "R8 count kept");
        do_steps(1, 1'b1, "R8 R5 disarm");
        chk(buzzer == 0 && blink == 0, "R5", {buzzer, 1'b0}, 0);
        @(negedge clk);
        chk(disarmed == 0, "R5 one cycle", disarmed, 0);
    endtask

    task automatic t_wrong;
        int t;
        pulse(cancel_req);
        chk(buzzer == 0, "R9", buzzer, 0);
        do_steps(5, 1'b0, "R4");
        get_target(t, "R6");
        press((t + 1) % 6);
        chk(disarmed == 0, "R6", disarmed, 0);
        get_target(t, "R6");
        @(negedge clk); btn = 6'(1) << t | 6'(1) << ((t + 3) % 6);
        @(negedge clk); btn = '0;
        chk(disarmed == 0, "R6 multi", disarmed, 0);
        do_steps(9, 1'b0, "R6 count cleared");
        chk(buzzer == 0, "R9 silent", buzzer, 0);
        do_steps(1, 1'b1, "R6 R9 disarm");
    endtask

    task automatic t_hold;
        int t;
        pulse(cancel_req);
        get_target(t, "R7");
        @(negedge clk); btn = 6'(1) << t;
        repeat (6) @(negedge clk);
        btn = '0;
        @(negedge clk);
        do_steps(8, 1'b0, "R7 held once");
        do_steps(1, 1'b1, "R7 disarm");
    endtask

    task automatic t_late_fire;
        pulse(cancel_req);
        do_steps(2, 1'b0, "R9");
        chk(buzzer == 0, "R9", buzzer, 0);
        pulse(alarm_fire);
        chk(buzzer == 1, "R10", buzzer, 1);
        do_steps(7, 1'b0, "R10 count kept");
        do_steps(1, 1'b1, "R10 disarm");
        chk(buzzer == 0, "R10 R5", buzzer, 0);
    endtask

    initial begin
        t_reset();
        t_snooze();
        t_wrong();
        t_hold();
        t_late_fire();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule